// File: doc/BRIEF.md
# Interrupt EOI Storm Throttler

This block holds the redirection entries of a small pin-based interrupt controller and handles end-of-interrupt (EOI) broadcasts for them. Each pin has an entry with a vector, a trigger mode, a mask bit and a read-only remote-IRR bit. It also has a request bit and a counter of successive EOI-driven redeliveries. An EOI broadcast clears remote-IRR on every level-triggered entry whose vector matches. If such a pin is still requesting and unmasked, it is normally serviced again at once.

A level interrupt that stays asserted can cause an endless loop of delivery and EOI. To prevent this, the per-pin counter counts successive redeliveries. When the counter hits `STORM_MAX`, the block does not redeliver at once. It clears the counter and arms a shared delay timer of `DELAY_CYCLES` clocks (10 ms at 200 MHz by default). When the timer expires, every pending, unmasked and eligible pin is serviced.

Software writes an entry through a plain write port and reads it through a combinational read port. Deliveries leave through a valid/ready stream. Once `deliver_valid` is high, the pin and vector stay stable until `deliver_ready` is sampled high. A delivery is committed when it is loaded into the output register, so back-pressure only delays the handshake and never withdraws a delivery.

Top module: `eoi_storm_throttler`

## Requirements
- R1: An EOI with `eoi_vector` equal to an entry's vector clears that entry's remote-IRR (entry bit VEC_W+2) when the entry is level-triggered (entry bit VEC_W = 1). A non-matching entry keeps its remote-IRR.
- R2: On a matching EOI, an unmasked pin whose request is still set is serviced at once, as long as this is not the `STORM_MAX`-th successive redelivery. `deliver_valid` rises two clock edges after the EOI edge.
- R3: On the `STORM_MAX`-th successive EOI redelivery of a pin, there is no immediate delivery. The counter returns to zero, so the next EOI after that is serviced at once.
- R4: A storm arms the delay timer. Exactly `DELAY_CYCLES` edges after the arming EOI edge, every pending, unmasked and eligible pin is serviced. The first delivery appears one edge later.
- R5: A storm that occurs while the timer is armed does not restart it, so the earlier expiry is kept.
- R6: A matching EOI on a pin that is masked or not requesting resets that pin's counter to zero.
- R7: Counters are kept per pin. Storms on two pins with different vectors are counted independently.
- R8: An entry write leaves remote-IRR unchanged for a level-triggered entry and resets that pin's counter.
- R9: A write that selects edge trigger clears remote-IRR. Every write runs the service routine over all pins.
- R10: `deliver_valid`, `deliver_pin` and `deliver_vector` stay stable while `deliver_ready` is low. Among pins being serviced, the lowest index goes first. Delivering a level-triggered pin sets its remote-IRR; delivering an edge-triggered pin does not.
- R11: After reset every entry reads vector 0, edge trigger, masked (entry bit VEC_W+1 = 1) and remote-IRR 0, and `deliver_valid` is low.
- R12: A rising pin level requests service. A masked pin with a pending request is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | NUM_PINS | Interrupt pin levels |
| wr_en | input | 1 | Entry write strobe |
| wr_pin | input | PIN_W | Entry index for the write (below NUM_PINS) |
| wr_data | input | VEC_W+3 | {ignored, masked, level, vector} |
| eoi_valid | input | 1 | EOI broadcast strobe, accepted every cycle |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| rd_pin | input | PIN_W | Entry index for the read (below NUM_PINS) |
| rd_entry | output | VEC_W+3 | {remote_irr, masked, level, vector} of the selected entry |
| deliver_valid | output | 1 | A delivery is offered |
| deliver_ready | input | 1 | Consumer accepts the delivery |
| deliver_pin | output | PIN_W | Pin being delivered |
| deliver_vector | output | VEC_W | Vector being delivered |

## Verification
An EOI, a write or a timer expiry marks pins for service on the edge that samples it, and the output register loads a delivery on the following edge. For that reason the bench expects `deliver_valid` two edges after an EOI or a pin rise, one edge after a write's own edge, and `DELAY_CYCLES + 1` edges after the storm edge. Remote-IRR changes are visible on `rd_entry` just after the edge that samples the EOI or write. Every check waits exactly that many edges, with a free-running edge counter used for the long timer window, and samples 1 ns after the edge.

// File: rtl/eoi_thr_pkg.sv
package eoi_thr_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // upper three bits of an entry, above the vector field
  typedef struct packed {
    logic  rirr;
    logic  masked;
    trig_e trig;
  } pin_ctl_t;

endpackage

// File: rtl/eoi_thr_pin.sv
module eoi_thr_pin
  import eoi_thr_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int STORM_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             wr_hit,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             wr_masked,
  input  trig_e            wr_trig,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             load,
  input  logic             svc_all,
  output logic [VEC_W-1:0] vec_q,
  output pin_ctl_t         ctl_q,
  output logic             elig,
  output logic             svc_q,
  output logic             delay_req
);
  localparam int CNT_W = $clog2(STORM_MAX + 1);

  logic             pin_prev;
  logic             irr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             eoi_hit;
  logic             pend_ok;
  logic             storm_hit;
  logic             eoi_svc;

  assign rise      = pin_in & ~pin_prev;
  assign eoi_hit   = eoi_valid && (vec_q == eoi_vector) && (ctl_q.trig == TRIG_LEVEL);
  assign pend_ok   = irr_q & ~ctl_q.masked;
  assign storm_hit = eoi_hit && pend_ok && (cnt_q == CNT_W'(STORM_MAX - 1));
  assign eoi_svc   = eoi_hit && pend_ok && !storm_hit;
  assign delay_req = storm_hit;
  assign elig      = irr_q & ~ctl_q.masked & ~((ctl_q.trig == TRIG_LEVEL) & ctl_q.rirr);

  // request bit: follows the level, or latches an edge until delivered
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_prev <= 1'b0;
      irr_q    <= 1'b0;
    end else begin
      pin_prev <= pin_in;
      if (ctl_q.trig == TRIG_LEVEL) irr_q <= pin_in;
      else                          irr_q <= (irr_q & ~load) | rise;
    end
  end

  // successive redelivery counter
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_hit)  cnt_q <= '0;
    else if (eoi_hit) begin
      if (!pend_ok || storm_hit) cnt_q <= '0;
      else                       cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // entry fields and remote-IRR
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q        <= '0;
      ctl_q.masked <= 1'b1;
      ctl_q.trig   <= TRIG_EDGE;
      ctl_q.rirr   <= 1'b0;
    end else begin
      if (wr_hit) begin
        vec_q        <= wr_vec;
        ctl_q.masked <= wr_masked;
        ctl_q.trig   <= wr_trig;
      end
      if (wr_hit && wr_trig == TRIG_EDGE)         ctl_q.rirr <= 1'b0;
      else if (load && ctl_q.trig == TRIG_LEVEL)  ctl_q.rirr <= 1'b1;
      else if (eoi_hit)                           ctl_q.rirr <= 1'b0;
    end
  end

  // service mark: dropped once delivered or found ineligible
  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= 1'b0;
    else        svc_q <= (svc_q & elig & ~load) | rise | eoi_svc | svc_all;
  end

endmodule

// File: rtl/eoi_thr_pick.sv
module eoi_thr_pick #(
  parameter int N     = 8,
  parameter int PIN_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic             any,
  output logic [PIN_W-1:0] idx
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
        idx    = PIN_W'(i);
      end
    end
  end
endmodule

// File: rtl/eoi_thr_delay.sv
module eoi_thr_delay #(
  parameter int DELAY_CYCLES = 2000000,
  localparam int TMR_W = $clog2(DELAY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_req,
  output logic             expire,
  output logic             armed,
  output logic [TMR_W-1:0] cnt
);
  assign expire = armed && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (expire) begin
      armed <= arm_req;
      cnt   <= TMR_W'(DELAY_CYCLES - 1);
    end else if (armed) begin
      cnt   <= cnt - TMR_W'(1);
    end else if (arm_req) begin
      armed <= 1'b1;
      cnt   <= TMR_W'(DELAY_CYCLES - 1);
    end
  end
endmodule

// File: rtl/eoi_storm_throttler.sv
module eoi_storm_throttler
  import eoi_thr_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int VEC_W        = 8,
  parameter int STORM_MAX    = 4,
  parameter int DELAY_CYCLES = 2000000,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ENTRY_W = VEC_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                wr_en,
  input  logic [PIN_W-1:0]    wr_pin,
  input  logic [ENTRY_W-1:0]  wr_data,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  input  logic [PIN_W-1:0]    rd_pin,
  output logic [ENTRY_W-1:0]  rd_entry,
  output logic                deliver_valid,
  input  logic                deliver_ready,
  output logic [PIN_W-1:0]    deliver_pin,
  output logic [VEC_W-1:0]    deliver_vector
);
  localparam int TMR_W = $clog2(DELAY_CYCLES + 1);

  logic [VEC_W-1:0]          vec_arr [NUM_PINS];
  pin_ctl_t                  ctl_arr [NUM_PINS];
  logic [NUM_PINS-1:0]       elig_vec;
  logic [NUM_PINS-1:0]       svc_vec;
  logic [NUM_PINS-1:0]       delay_vec;
  logic [NUM_PINS-1:0]       cand_vec;
  logic [NUM_PINS-1:0]       pick_vec;
  logic [NUM_PINS-1:0]       grant_vec;
  logic [NUM_PINS-1:0]       rirr_vec;
  logic [NUM_PINS-1:0]       level_vec;
  logic [NUM_PINS*VEC_W-1:0] vec_flat;
  logic                      pick_any;
  logic [PIN_W-1:0]          pick_idx;
  logic                      can_load;
  logic                      tmr_expire;
  logic                      tmr_armed;
  logic [TMR_W-1:0]          tmr_cnt;
  logic                      svc_all;

  assign svc_all = wr_en | tmr_expire;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    eoi_thr_pin #(
      .VEC_W     (VEC_W),
      .STORM_MAX (STORM_MAX)
    ) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (irq_pins[n]),
      .wr_hit     (wr_en && (wr_pin == PIN_W'(n))),
      .wr_vec     (wr_data[VEC_W-1:0]),
      .wr_masked  (wr_data[VEC_W+1]),
      .wr_trig    (trig_e'(wr_data[VEC_W])),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .load       (grant_vec[n]),
      .svc_all    (svc_all),
      .vec_q      (vec_arr[n]),
      .ctl_q      (ctl_arr[n]),
      .elig       (elig_vec[n]),
      .svc_q      (svc_vec[n]),
      .delay_req  (delay_vec[n])
    );
    assign rirr_vec[n]                  = ctl_arr[n].rirr;
    assign level_vec[n]                 = (ctl_arr[n].trig == TRIG_LEVEL);
    assign vec_flat[n*VEC_W +: VEC_W]   = vec_arr[n];
  end

  assign cand_vec = svc_vec & elig_vec;

  eoi_thr_pick #(
    .N     (NUM_PINS),
    .PIN_W (PIN_W)
  ) u_pick (
    .req (cand_vec),
    .gnt (pick_vec),
    .any (pick_any),
    .idx (pick_idx)
  );

  eoi_thr_delay #(
    .DELAY_CYCLES (DELAY_CYCLES)
  ) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_req (|delay_vec),
    .expire  (tmr_expire),
    .armed   (tmr_armed),
    .cnt     (tmr_cnt)
  );

  // output register: a delivery is committed when loaded
  assign can_load  = ~deliver_valid | deliver_ready;
  assign grant_vec = can_load ? pick_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deliver_valid  <= 1'b0;
      deliver_pin    <= '0;
      deliver_vector <= '0;
    end else if (can_load) begin
      deliver_valid <= pick_any;
      if (pick_any) begin
        deliver_pin    <= pick_idx;
        deliver_vector <= vec_arr[pick_idx];
      end
    end
  end

  assign rd_entry = {ctl_arr[rd_pin], vec_arr[rd_pin]};

endmodule

// File: rtl/eoi_storm_throttler_chk.sv
module eoi_storm_throttler_chk #(
  parameter int NUM_PINS     = 8,
  parameter int VEC_W        = 8,
  parameter int DELAY_CYCLES = 2000000,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int TMR_W   = $clog2(DELAY_CYCLES + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [PIN_W-1:0]          wr_pin,
  input logic [VEC_W+2:0]          wr_data,
  input logic                      eoi_valid,
  input logic [VEC_W-1:0]          eoi_vector,
  input logic                      deliver_valid,
  input logic                      deliver_ready,
  input logic [PIN_W-1:0]          deliver_pin,
  input logic [VEC_W-1:0]          deliver_vector,
  input logic [NUM_PINS-1:0]       rirr_vec,
  input logic [NUM_PINS-1:0]       level_vec,
  input logic [NUM_PINS-1:0]       grant_vec,
  input logic [NUM_PINS*VEC_W-1:0] vec_flat,
  input logic                      tmr_armed,
  input logic [TMR_W-1:0]          tmr_cnt
);

  // R10: stream holds under back-pressure
  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_valid && !deliver_ready |=>
      deliver_valid && $stable(deliver_pin) && $stable(deliver_vector));

  // R10: at most one pin committed per cycle
  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R5: an armed timer counts down without restarting
  a_r5_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_armed && tmr_cnt != '0 |=> tmr_armed && tmr_cnt == $past(tmr_cnt) - TMR_W'(1));

  // R8: a level write with no other event leaves remote-IRR alone
  a_r8_write_keeps_rirr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[VEC_W] && !eoi_valid && grant_vec == '0 |=> rirr_vec == $past(rirr_vec));

  // R9: an edge-mode write clears remote-IRR of that entry
  a_r9_edge_fixup: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[VEC_W] |=> !rirr_vec[$past(wr_pin)]);

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_r1
    // R1: matching level EOI clears remote-IRR unless redelivered at once
    a_r1_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid && vec_flat[n*VEC_W +: VEC_W] == eoi_vector && level_vec[n] &&
      !wr_en && !grant_vec[n] |=> !rirr_vec[n]);
  end

endmodule

bind eoi_storm_throttler eoi_storm_throttler_chk #(
  .NUM_PINS     (NUM_PINS),
  .VEC_W        (VEC_W),
  .DELAY_CYCLES (DELAY_CYCLES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_pin         (wr_pin),
  .wr_data        (wr_data),
  .eoi_valid      (eoi_valid),
  .eoi_vector     (eoi_vector),
  .deliver_valid  (deliver_valid),
  .deliver_ready  (deliver_ready),
  .deliver_pin    (deliver_pin),
  .deliver_vector (deliver_vector),
  .rirr_vec       (rirr_vec),
  .level_vec      (level_vec),
  .grant_vec      (grant_vec),
  .vec_flat       (vec_flat),
  .tmr_armed      (tmr_armed),
  .tmr_cnt        (tmr_cnt)
);

// File: tb/eoi_storm_throttler_test.sv
`timescale 1ns/1ps
module eoi_storm_throttler_test;
  localparam int NP   = 4;
  localparam int VW   = 8;
  localparam int SMAX = 3;
  localparam int DLY  = 40;
  localparam int PW   = 2;
  localparam int EW   = VW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] irq_pins = '0;
  logic          wr_en = 1'b0;
  logic [PW-1:0] wr_pin = '0;
  logic [EW-1:0] wr_data = '0;
  logic          eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic [PW-1:0] rd_pin = '0;
  logic [EW-1:0] rd_entry;
  logic          deliver_valid;
  logic          deliver_ready = 1'b0;
  logic [PW-1:0] deliver_pin;
  logic [VW-1:0] deliver_vector;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int p = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eoi_storm_throttler #(
    .NUM_PINS(NP), .VEC_W(VW), .STORM_MAX(SMAX), .DELAY_CYCLES(DLY)
  ) uut (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .wr_en(wr_en), .wr_pin(wr_pin),
    .wr_data(wr_data), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .rd_pin(rd_pin),
    .rd_entry(rd_entry), .deliver_valid(deliver_valid), .deliver_ready(deliver_ready),
    .deliver_pin(deliver_pin), .deliver_vector(deliver_vector)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic write_entry(int pin, int data);
    wr_en = 1'b1; wr_pin = PW'(pin); wr_data = EW'(data);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_eoi(int vec);
    eoi_valid = 1'b1; eoi_vector = VW'(vec);
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic accept();
    deliver_ready = 1'b1;
    tick();
    deliver_ready = 1'b0;
  endtask

  task automatic rirr_of(int pin, output int r);
    rd_pin = PW'(pin);
    #0.5;
    r = int'(rd_entry[VW+2]);
  endtask

  task automatic expect_del(string req, int pin, int vec);
    check(req, int'(deliver_valid), 1);
    check(req, int'(deliver_pin), pin);
    check(req, int'(deliver_vector), vec);
  endtask

  // R11
  task automatic t_reset();
    check("R11 valid", int'(deliver_valid), 0);
    rd_pin = 0; #0.5;
    check("R11 entry0", int'(rd_entry), 'h200);
    rd_pin = 3; #0.5;
    check("R11 entry3", int'(rd_entry), 'h200);
  endtask

  // R12 and R10
  task automatic t_first();
    int r;
    write_entry(0, 'h131);
    write_entry(1, 'h340);
    write_entry(2, 'h150);
    write_entry(3, 'h160);
    tick(); tick();
    check("R12 idle", int'(deliver_valid), 0);
    irq_pins[0] = 1'b1;
    tick(); tick();
    expect_del("R12 rise", 0, 'h31);
    for (int i = 0; i < 3; i++) begin
      tick();
      expect_del("R10 hold", 0, 'h31);
    end
    rirr_of(0, r);
    check("R10 level sets rirr", r, 1);
    accept();
    check("R10 drained", int'(deliver_valid), 0);
    irq_pins[1] = 1'b1;
    tick(); tick(); tick();
    check("R12 masked", int'(deliver_valid), 0);
  endtask

  // R1 R2 R3 R4
  task automatic t_storm();
    int r;
    do_eoi('h31);
    rirr_of(0, r);
    check("R1 cleared", r, 0);
    tick();
    expect_del("R2 first", 0, 'h31);
    accept();
    do_eoi('h31); tick();
    expect_del("R2 second", 0, 'h31);
    accept();
    do_eoi('h31);
    p = cyc;
    tick();
    check("R3 no immediate", int'(deliver_valid), 0);
    rirr_of(0, r);
    check("R3 rirr clear", r, 0);
    while (cyc < p + DLY) tick();
    check("R4 not before", int'(deliver_valid), 0);
    tick();
    expect_del("R4 expiry", 0, 'h31);
    accept();
    do_eoi('h31); tick();
    expect_del("R3 counter reset", 0, 'h31);
    accept();
  endtask

  // R6
  task automatic t_not_pending();
    irq_pins[0] = 1'b0;
    tick();
    do_eoi('h31); tick();
    check("R6 idle pin", int'(deliver_valid), 0);
    irq_pins[0] = 1'b1;
    tick(); tick();
    expect_del("R6 rise", 0, 'h31);
    accept();
    do_eoi('h31); tick();
    expect_del("R6 eoi1", 0, 'h31);
    accept();
    do_eoi('h31); tick();
    expect_del("R6 eoi2", 0, 'h31);
    accept();
  endtask

  // R8
  task automatic t_write();
    int r;
    write_entry(0, 'h131);
    rirr_of(0, r);
    check("R8 rirr kept", r, 1);
    tick();
    check("R8 no delivery", int'(deliver_valid), 0);
    do_eoi('h31); tick();
    expect_del("R8 counter reset", 0, 'h31);
    accept();
  endtask

  // R9 and R10 edge
  task automatic t_write_service();
    int r;
    write_entry(1, 'h140);
    tick();
    expect_del("R9 service on write", 1, 'h40);
    accept();
    write_entry(0, 'h031);
    rirr_of(0, r);
    check("R9 edge fixup", r, 0);
    tick();
    expect_del("R9 edge pending", 0, 'h31);
    accept();
    rirr_of(0, r);
    check("R10 edge no rirr", r, 0);
    check("R9 drained", int'(deliver_valid), 0);
  endtask

  // R10 priority
  task automatic t_priority();
    irq_pins[3:2] = 2'b11;
    tick(); tick();
    expect_del("R10 lowest first", 2, 'h50);
    accept();
    expect_del("R10 next", 3, 'h60);
    accept();
    check("R10 empty", int'(deliver_valid), 0);
  endtask

  // R7 R5 R4 R1
  task automatic t_per_pin();
    int r;
    do_eoi('h50); tick();
    expect_del("R7 p2 a", 2, 'h50);
    accept();
    do_eoi('h60); tick();
    expect_del("R7 p3 a", 3, 'h60);
    rirr_of(2, r);
    check("R1 other vector kept", r, 1);
    accept();
    do_eoi('h50); tick();
    expect_del("R7 p2 b", 2, 'h50);
    accept();
    do_eoi('h60); tick();
    expect_del("R7 p3 b", 3, 'h60);
    accept();
    do_eoi('h50);
    p = cyc;
    tick();
    check("R7 p2 storm", int'(deliver_valid), 0);
    do_eoi('h60); tick();
    check("R7 p3 storm", int'(deliver_valid), 0);
    while (cyc < p + DLY) tick();
    check("R5 not before", int'(deliver_valid), 0);
    tick();
    expect_del("R5 first expiry", 2, 'h50);
    accept();
    expect_del("R4 all pins", 3, 'h60);
    accept();
    check("R4 done", int'(deliver_valid), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_first();
    t_storm();
    t_not_pending();
    t_write();
    t_write_service();
    t_priority();
    t_per_pin();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule